// File: doc/BRIEF.md
# Leveled Interrupt Priority Arbiter

The block takes 64 interrupt request lines. Each line has its own 3-bit priority level, set through a small register port. On every clock the block finds the pending line that should be serviced next and presents it in registered form: a request flag, the winning level and the 6-bit source number. A higher level wins. Among lines that share the winning level, the higher source number wins. Level 0 turns a line off.

A 4-bit current mask value sets a threshold: only a line whose level is strictly above it can take part. The processor acknowledges the presented request with a one-cycle pulse. When the mask-enable bit is set, that pulse moves the current mask into a saved-mask register and raises the current mask to the acknowledged level. Requests at that level and below are then held off until software restores the mask.

The register port uses a flat index. Indexes 0 to 63 address the level registers, 64 the configuration, 65 the current mask and 66 the saved mask. Reads are combinational and take effect in the same cycle.

Top module: `irq_level_arb`

## Requirements
- R1: After reset the request flag is 0. Every level register reads 0x00, the configuration reads 0x00, the current mask reads 0x00 and the saved mask reads 0x0F.
- R2: Register indexes are: 0..63 the level of source n (bits 2..0), 64 the configuration (bit 0 is mask enable), 65 the current mask (bits 3..0), 66 the saved mask (bits 3..0). Bits above each field read 0 and ignore writes.
- R3: A source whose level is 0 is never presented, even while its line is high.
- R4: Among the eligible pending sources, the one with the highest level is presented.
- R5: When eligible sources tie on the highest level, the one with the highest source number is presented. For example, 63, 62, 2 and 1 at one level are served in that order as each drops.
- R6: A pending source is eligible only if its level is strictly greater than the current mask. The request flag is 0 when no source is eligible.
- R7: With mask enable set, an acknowledge pulse while the request flag is 1 copies the current mask into the saved mask. In the same edge it sets the current mask to the presented level, so that level and all lower levels are held off.
- R8: With mask enable clear, an acknowledge pulse changes neither mask register, and the presented request is unchanged.
- R9: The presented flag, level and source are registered. They reflect a change on the request lines one clock edge later.
- R10: A write to a level or mask register, or an acknowledge, takes effect in the arbitration one edge after the register updates, which is two edges after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 64 | Interrupt request lines, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Flat register index |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| ack_i | input | 1 | Single-cycle acknowledge pulse |
| req_o | output | 1 | A request is presented |
| lvl_o | output | 3 | Level of the presented request |
| src_o | output | 6 | Source number of the presented request |

## Verification
A change on the request lines shows at the outputs one edge after the driving cycle. A register write or an acknowledge needs two edges: one to update the register and one to re-arbitrate. The driver stamps each expected result with the cycle in which it is due, counting from the cycle it drove the stimulus. The monitor compares each result in exactly that cycle, sampled just after the edge. Register reads are combinational and are compared in the cycle the index is applied.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned MASK_W = 4;
  localparam int unsigned DATA_W = 8;
  localparam logic [MASK_W-1:0] SAVED_RST = '1;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/irq_level_regs.sv
module irq_level_regs
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  lvl_t              wdata_i,
  output lvl_t              lvl_o [NUM_SRC]
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lvl_o[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))     lvl_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  mask_t             wdata_i,
  input  logic              ack_i,
  input  logic              ack_valid_i,
  input  lvl_t              ack_lvl_i,
  output logic              mask_en_o,
  output mask_t             cur_o,
  output mask_t             saved_o
);
  localparam logic [ADDR_W-1:0] CFG_IDX = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] CUR_IDX = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] SAV_IDX = ADDR_W'(NUM_SRC + 2);

  logic auto_mask;
  assign auto_mask = ack_i && ack_valid_i && mask_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_en_o <= 1'b0;
    else if (we_i && addr_i == CFG_IDX) mask_en_o <= wdata_i[0];
  end

  // acknowledge wins over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_o   <= '0;
      saved_o <= SAVED_RST;
    end else if (auto_mask) begin
      saved_o <= cur_o;
      cur_o   <= MASK_W'(ack_lvl_i);
    end else if (we_i) begin
      if (addr_i == CUR_IDX) cur_o   <= wdata_i;
      if (addr_i == SAV_IDX) saved_o <= wdata_i;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned SRC_W   = 6
) (
  input  logic [NUM_SRC-1:0] irq_i,
  input  lvl_t               lvl_i [NUM_SRC],
  input  mask_t              cur_i,
  output logic               hit_o,
  output lvl_t               lvl_o,
  output logic [SRC_W-1:0]   src_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = irq_i[g] && (MASK_W'(lvl_i[g]) > cur_i);
  end

  // ">=" lets a later (higher) index take a tie
  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    src_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && lvl_i[i] >= lvl_o) begin
        hit_o = 1'b1;
        lvl_o = lvl_i[i];
        src_o = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC),
  localparam int unsigned ADDR_W = $clog2(NUM_SRC + 3)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               ack_i,
  output logic               req_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [SRC_W-1:0]   src_o
);
  localparam logic [ADDR_W-1:0] CFG_IDX = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] CUR_IDX = ADDR_W'(NUM_SRC + 1);
  localparam logic [ADDR_W-1:0] SAV_IDX = ADDR_W'(NUM_SRC + 2);

  lvl_t             lvl_q [NUM_SRC];
  logic             mask_en;
  mask_t            cur_mask;
  mask_t            saved_mask;
  logic             hit_d;
  lvl_t             lvl_d;
  logic [SRC_W-1:0] src_d;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:MASK_W];

  irq_level_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i[LVL_W-1:0]),
    .lvl_o   (lvl_q)
  );

  irq_mask_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_mask (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i[MASK_W-1:0]),
    .ack_i       (ack_i),
    .ack_valid_i (req_o),
    .ack_lvl_i   (lvl_o),
    .mask_en_o   (mask_en),
    .cur_o       (cur_mask),
    .saved_o     (saved_mask)
  );

  irq_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) i_pick (
    .irq_i (irq_i),
    .lvl_i (lvl_q),
    .cur_i (cur_mask),
    .hit_o (hit_d),
    .lvl_o (lvl_d),
    .src_o (src_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      lvl_o <= '0;
      src_o <= '0;
    end else begin
      req_o <= hit_d;
      lvl_o <= lvl_d;
      src_o <= src_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < CFG_IDX)       reg_rdata_o = DATA_W'(lvl_q[reg_addr_i[SRC_W-1:0]]);
    else if (reg_addr_i == CFG_IDX) reg_rdata_o = DATA_W'(mask_en);
    else if (reg_addr_i == CUR_IDX) reg_rdata_o = DATA_W'(cur_mask);
    else if (reg_addr_i == SAV_IDX) reg_rdata_o = DATA_W'(saved_mask);
  end
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               reg_we_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               ack_i,
  input logic               req_o,
  input logic [LVL_W-1:0]   lvl_o,
  input logic               mask_en,
  input mask_t              cur_mask,
  input mask_t              saved_mask
);
  a_r2_rsv_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[DATA_W-1:MASK_W] == '0));

  a_r3_no_zero_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (lvl_o != '0));

  a_r6_above_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (MASK_W'(lvl_o) > $past(cur_mask)));

  a_r7_ack_saves_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && mask_en && req_o) |=>
      (saved_mask == $past(cur_mask)) && (cur_mask == MASK_W'($past(lvl_o))));

  a_r8_ack_no_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !mask_en && !reg_we_i) |=> ($stable(cur_mask) && $stable(saved_mask)));

  a_r9_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i == '0) |=> !req_o);
endmodule

bind irq_level_arb irq_level_arb_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .ack_i       (ack_i),
  .req_o       (req_o),
  .lvl_o       (lvl_o),
  .mask_en     (mask_en),
  .cur_mask    (cur_mask),
  .saved_mask  (saved_mask)
);

// File: tb/test_irq_level_arb.sv
module test_irq_level_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 64;
  localparam int CFG = 64, CUR = 65, SAV = 66;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ack = 1'b0;
  logic        req;
  logic [2:0]  lvl;
  logic [5:0]  src;

  int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
  bit done = 0;

  typedef struct {
    int    due;
    bit    req;
    int    lvl;
    int    src;
    string tag;
  } exp_t;
  exp_t q[$];

  irq_level_arb #(.NUM_SRC(NSRC)) i_irq_level_arb (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_i(ack), .req_o(req),
    .lvl_o(lvl), .src_o(src)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares each expected item in its due cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (req !== e.req || (e.req && (int'(lvl) != e.lvl || int'(src) != e.src))) begin
          errors++;
          $display("FAIL %s: got req=%0b lvl=%0d src=%0d, expected req=%0b lvl=%0d src=%0d",
                   e.tag, req, lvl, src, e.req, e.lvl, e.src);
        end
      end
    end
  end

  task automatic expect_out(string tag, int dly, bit r, int l, int s);
    exp_t e;
    e.due = last_cyc + dly; e.req = r; e.lvl = l; e.src = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_irq(int n, bit v);
    @(negedge clk);
    irq[n] = v;
    last_cyc = cyc;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = 7'(a); wdata = 8'(d);
    last_cyc = cyc;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    last_cyc = cyc;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic chk_rd(string tag, int a, int exp);
    @(negedge clk);
    addr = 7'(a);
    #1;
    checks++;
    if (int'(rdata) != exp) begin
      errors++;
      $display("FAIL %s: index %0d read 0x%02h, expected 0x%02h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_now(string tag, bit r);
    checks++;
    if (req !== r) begin
      errors++;
      $display("FAIL %s: req=%0b, expected %0b", tag, req, r);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_now("R1 req after reset", 1'b0);
    chk_rd("R1 level reg", 17, 8'h00);
    chk_rd("R1 config", CFG, 8'h00);
    chk_rd("R1 current mask", CUR, 8'h00);
    chk_rd("R1 saved mask", SAV, 8'h0F);

    // R2 reserved bits
    wr(5, 8'hFF);
    chk_rd("R2 level reserved bits", 5, 8'h07);
    wr(SAV, 8'hFA);
    chk_rd("R2 saved reserved bits", SAV, 8'h0A);
    wr(5, 0);

    // R3 level zero disabled
    set_irq(3, 1);
    expect_out("R3 level 0 line", 1, 0, 0, 0);
    settle();

    // R4 highest level wins, R9 one-edge latency
    wr(10, 2); wr(20, 5); wr(30, 3);
    set_irq(10, 1); expect_out("R9 single source", 1, 1, 2, 10); settle();
    set_irq(30, 1); expect_out("R4 higher level wins", 1, 1, 3, 30); settle();
    set_irq(20, 1); expect_out("R4 highest of three", 1, 1, 5, 20); settle();
    set_irq(20, 0); expect_out("R4 fall back", 1, 1, 3, 30); settle();
    set_irq(10, 0); set_irq(30, 0);
    expect_out("R6 none pending", 1, 0, 0, 0); settle();

    // R5 ties by descending source number
    wr(63, 6); wr(62, 6); wr(2, 6); wr(1, 6);
    set_irq(1, 1); set_irq(2, 1); set_irq(62, 1); set_irq(63, 1);
    expect_out("R5 tie picks 63", 1, 1, 6, 63); settle();
    set_irq(63, 0); expect_out("R5 then 62", 1, 1, 6, 62); settle();
    set_irq(62, 0); expect_out("R5 then 2", 1, 1, 6, 2); settle();
    set_irq(2, 0);  expect_out("R5 then 1", 1, 1, 6, 1); settle();
    set_irq(1, 0);  expect_out("R5 drained", 1, 0, 0, 0); settle();

    // R6 threshold, R10 two-edge latency of mask writes
    set_irq(20, 1); set_irq(30, 1);
    expect_out("R6 both pending", 1, 1, 5, 20); settle();
    wr(CUR, 4); expect_out("R10 mask 4 keeps level 5", 2, 1, 5, 20); settle();
    wr(CUR, 5); expect_out("R6 mask equal to level blocks", 2, 0, 0, 0); settle();
    wr(CUR, 2); expect_out("R10 mask 2 re-enables", 2, 1, 5, 20); settle();
    wr(20, 1);  expect_out("R10 level write lowers source", 2, 1, 3, 30); settle();
    wr(20, 5);  expect_out("R10 level restored", 2, 1, 5, 20); settle();
    wr(CUR, 0); settle();

    // R8 ack without mask enable
    pulse_ack();
    expect_out("R8 request unchanged after ack", 2, 1, 5, 20); settle();
    chk_rd("R8 current mask unchanged", CUR, 8'h00);
    chk_rd("R8 saved mask unchanged", SAV, 8'h0A);

    // R7 ack with mask enable
    wr(CFG, 8'h01);
    chk_rd("R2 config bit", CFG, 8'h01);
    pulse_ack();
    expect_out("R7 ack masks level 5 and below", 2, 0, 0, 0); settle();
    chk_rd("R7 current mask raised", CUR, 8'h05);
    chk_rd("R7 saved mask holds old", SAV, 8'h00);
    set_irq(20, 0); settle();
    wr(CUR, 0); expect_out("R7 restore re-enables", 2, 1, 3, 30); settle();
    pulse_ack();
    expect_out("R7 second ack masks level 3", 2, 0, 0, 0); settle();
    chk_rd("R7 current mask 3", CUR, 8'h03);
    chk_rd("R7 saved mask 0", SAV, 8'h00);
    wr(CUR, 2); expect_out("R6 mask 2 admits level 3", 2, 1, 3, 30); settle();

    set_irq(30, 0); set_irq(3, 0);
    expect_out("R6 idle", 1, 0, 0, 0); settle();
    finish_run();
  end
endmodule